// File: doc/BRIEF.md
# Compare-and-Jump Condition Unit

This unit resolves a fused compare-and-branch instruction. It looks at a 32-bit instruction word and decides whether the instruction is a branch. A branch comes in one of two forms: a register-register form or a register-immediate form. For a branch, the unit compares the first register operand with either the second register operand or a sign-extended 16-bit immediate, using a 4-bit condition code. It then reports whether the branch is taken and which instruction pointer comes next. No flag register is involved. Each instruction carries its own comparison.

The surrounding core gives the unit the two register values it has already read, the current instruction pointer and the branch target. The outputs are registered by default, so the decision for an instruction appears one clock after that instruction is presented. A condition code outside the defined set raises an invalid-condition flag, which the core can turn into an invalid-opcode trap.

Top module: `cj_branch_unit`

## Requirements
- R1: While the asynchronous active-low reset is held, taken_o, bad_cond_o and next_ip_o all read 0.
- R2: With the default output register, the outputs reflect the inputs sampled at the previous rising clock edge. They do not reflect the inputs currently applied.
- R3: The instruction layout is opcode in bits [31:24], condition in [23:20], first-register index in [19:16] and immediate in [15:0]. Condition 0 always takes the branch, and next_ip_o then equals target_i.
- R4: Condition 1 is taken when the two operands are equal. Condition 2 is taken when they differ.
- R5: Condition 3 is taken when operand A is greater than operand B as unsigned numbers. Condition 4 is taken when A is greater than or equal to B as unsigned numbers.
- R6: Condition 5 is taken when A is greater than B in two's complement. Condition 6 is taken when A is greater than or equal to B in two's complement.
- R7: Opcode 0x40 selects the register form. Operand B is rs2_val_i, and bits [15:0] of the instruction have no effect.
- R8: Opcode 0x41 selects the immediate form. Operand B is bits [15:0] sign-extended to 32 bits, and rs2_val_i has no effect.
- R9: In either branch form, condition codes 7 to 15 set bad_cond_o to 1, hold taken_o at 0 and give next_ip_o = ip_i + 1.
- R10: Any other opcode leaves the unit idle: taken_o is 0, bad_cond_o is 0 and next_ip_o is ip_i + 1.
- R11: When the branch is not taken, next_ip_o equals ip_i + 1 modulo 2^32, so 0xFFFFFFFF wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction word |
| rs1_val_i | input | 32 | Value of the first register operand (operand A) |
| rs2_val_i | input | 32 | Value of the second register operand |
| ip_i | input | 32 | Instruction pointer of this instruction |
| target_i | input | 32 | Branch destination used when taken |
| taken_o | output | 1 | Branch taken |
| next_ip_o | output | 32 | Next instruction pointer |
| bad_cond_o | output | 1 | Branch opcode carried an undefined condition |

## Verification
A faulty comparison flag inside the unit shows up as a wrong taken_o and next_ip_o one clock after the offending instruction. It can only be seen with operands that straddle the point where the signed and unsigned orders disagree, or with operands that are exactly equal. A wrong form decode shows up as a decision that follows rs2_val_i when the immediate should be used, or the other way round. The stimulus therefore pairs each form with operand values that make the two choices give different answers. A fault in the condition decode appears as a spurious or missing bad_cond_o, or as a taken branch on an undefined code, in the same cycle as the decision.

// File: rtl/cj_pkg.sv
package cj_pkg;

   typedef enum logic [1:0] {
      CJ_FORM_NONE = 2'd0,
      CJ_FORM_REG  = 2'd1,
      CJ_FORM_IMM  = 2'd2
   } cj_form_e;

   // condition codes; the numeric values are architectural
   localparam int CJ_C_ALWAYS = 0;
   localparam int CJ_C_EQ     = 1;
   localparam int CJ_C_NE     = 2;
   localparam int CJ_C_UGT    = 3;
   localparam int CJ_C_UGE    = 4;
   localparam int CJ_C_SGT    = 5;
   localparam int CJ_C_SGE    = 6;
   localparam int CJ_C_LAST   = CJ_C_SGE;

   typedef struct packed {
      logic eq;
      logic ugt;
      logic sgt;
   } cj_cmp_t;

endpackage

// File: rtl/cj_decode.sv
module cj_decode
   import cj_pkg::*;
#(
   parameter int          XLEN       = 32,
   parameter int          OPC_W      = 8,
   parameter int          COND_W     = 4,
   parameter int          IMM_W      = 16,
   parameter logic [7:0]  OPC_REG    = 8'h40,
   parameter logic [7:0]  OPC_IMM    = 8'h41,
   parameter bit          IMM_SIGNED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [XLEN-1:0]   instr,
   input  logic [XLEN-1:0]   rs2_val,
   output cj_form_e          form,
   output logic [COND_W-1:0] cond,
   output logic [XLEN-1:0]   opnd_b
);
   localparam int OPC_LSB  = XLEN - OPC_W;
   localparam int COND_LSB = OPC_LSB - COND_W;

   logic [OPC_W-1:0] opc;
   logic [IMM_W-1:0] imm;
   logic [XLEN-1:0]  imm_ext;

   assign opc  = instr[XLEN-1:OPC_LSB];
   assign cond = instr[OPC_LSB-1:COND_LSB];
   assign imm  = instr[IMM_W-1:0];

   // register index bits are resolved by the register file, not here
   generate
      if (COND_LSB > IMM_W) begin : g_idx_field
         logic unused_idx;
         assign unused_idx = ^instr[COND_LSB-1:IMM_W];
      end
   endgenerate

   generate
      if (IMM_SIGNED) begin : g_sext
         assign imm_ext = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
      end else begin : g_zext
         assign imm_ext = {{(XLEN-IMM_W){1'b0}}, imm};
      end
   endgenerate

   always_comb begin
      if (opc == OPC_W'(OPC_REG))      form = CJ_FORM_REG;
      else if (opc == OPC_W'(OPC_IMM)) form = CJ_FORM_IMM;
      else                             form = CJ_FORM_NONE;
   end

   always_comb begin
      unique case (form)
         CJ_FORM_IMM: opnd_b = imm_ext;
         default:     opnd_b = rs2_val;
      endcase
   end

   // R7: register form always compares against the second register value
   p_reg_operand_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (form == CJ_FORM_REG) |-> (opnd_b == rs2_val));

   // R8: in the immediate form the low bits of operand B follow the instruction
   p_imm_operand_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (form == CJ_FORM_IMM) |-> (opnd_b[IMM_W-1:0] == instr[IMM_W-1:0]));

endmodule

// File: rtl/cj_compare.sv
module cj_compare
   import cj_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter bit SHARED_SUB = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output cj_cmp_t         cmp
);
   localparam int MSB = XLEN - 1;

   logic eq;
   logic ugt;
   logic sgt;

   assign eq = (a == b);

   generate
      if (SHARED_SUB) begin : g_shared
         // one subtractor serves both orders; sign bits pick the result
         logic [XLEN:0] diff;
         logic          borrow;
         logic          slt;
         assign diff   = {1'b0, a} - {1'b0, b};
         assign borrow = diff[XLEN];
         assign slt    = (a[MSB] ^ b[MSB]) ? a[MSB] : borrow;
         assign ugt    = !borrow && !eq;
         assign sgt    = !slt && !eq;
      end else begin : g_split
         assign ugt = (a > b);
         assign sgt = ($signed(a) > $signed(b));
      end
   endgenerate

   assign cmp.eq  = eq;
   assign cmp.ugt = ugt;
   assign cmp.sgt = sgt;

   // R5: equal operands are never greater in either order
   p_eq_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmp.eq |-> (!cmp.ugt && !cmp.sgt));

   // R6: negative A against non-negative B is signed-smaller, unsigned-larger
   p_sign_split_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (a[MSB] && !b[MSB]) |-> (!cmp.sgt && cmp.ugt));

endmodule

// File: rtl/cj_select.sv
module cj_select
   import cj_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int COND_W  = 4,
   parameter int IP_STEP = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cj_form_e          form,
   input  logic [COND_W-1:0] cond,
   input  cj_cmp_t           cmp,
   input  logic [XLEN-1:0]   ip,
   input  logic [XLEN-1:0]   target,
   output logic              taken,
   output logic              bad,
   output logic [XLEN-1:0]   next_ip
);
   logic is_branch;
   logic hit;
   logic known;

   assign is_branch = (form != CJ_FORM_NONE);

   always_comb begin
      known = 1'b1;
      unique case (cond)
         COND_W'(CJ_C_ALWAYS): hit = 1'b1;
         COND_W'(CJ_C_EQ):     hit = cmp.eq;
         COND_W'(CJ_C_NE):     hit = !cmp.eq;
         COND_W'(CJ_C_UGT):    hit = cmp.ugt;
         COND_W'(CJ_C_UGE):    hit = cmp.ugt || cmp.eq;
         COND_W'(CJ_C_SGT):    hit = cmp.sgt;
         COND_W'(CJ_C_SGE):    hit = cmp.sgt || cmp.eq;
         default: begin
            hit   = 1'b0;
            known = 1'b0;
         end
      endcase
   end

   assign taken   = is_branch && hit;
   assign bad     = is_branch && !known;
   assign next_ip = taken ? target : (ip + XLEN'(IP_STEP));

   // R3: condition 0 on a branch opcode always resolves taken
   p_always_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (is_branch && (cond == '0)) |-> taken);

   // R9: an undefined condition never jumps
   p_bad_no_jump_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bad |-> (!taken && is_branch));

   // R3: taken branches go to the supplied target
   p_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
      taken |-> (next_ip == target));

endmodule

// File: rtl/cj_branch_unit.sv
module cj_branch_unit
   import cj_pkg::*;
#(
   parameter int          XLEN       = 32,
   parameter int          OPC_W      = 8,
   parameter int          COND_W     = 4,
   parameter int          RIDX_W     = 4,
   parameter int          IMM_W      = 16,
   parameter logic [7:0]  OPC_REG    = 8'h40,
   parameter logic [7:0]  OPC_IMM    = 8'h41,
   parameter bit          IMM_SIGNED = 1'b1,
   parameter bit          SHARED_SUB = 1'b1,
   parameter bit          OUT_REG    = 1'b1,
   parameter int          IP_STEP    = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [31:0]     instr_i,
   input  logic [31:0]     rs1_val_i,
   input  logic [31:0]     rs2_val_i,
   input  logic [31:0]     ip_i,
   input  logic [31:0]     target_i,
   output logic            taken_o,
   output logic [31:0]     next_ip_o,
   output logic            bad_cond_o
);
   localparam int FIELD_SUM = OPC_W + COND_W + RIDX_W + IMM_W;

   generate
      if (XLEN != 32) begin : g_chk_xlen
         $error("cj_branch_unit: port width fixed at 32, XLEN must match");
      end
      if (FIELD_SUM != XLEN) begin : g_chk_fields
         $error("cj_branch_unit: instruction fields must fill the word");
      end
      if (IMM_W >= XLEN) begin : g_chk_imm
         $error("cj_branch_unit: immediate must be narrower than the word");
      end
      if (COND_W < 3) begin : g_chk_cond
         $error("cj_branch_unit: condition field too narrow for seven codes");
      end
      if (OPC_W > 8) begin : g_chk_opc
         $error("cj_branch_unit: opcode parameters are 8 bits wide");
      end
      if (OPC_REG == OPC_IMM) begin : g_chk_opc_distinct
         $error("cj_branch_unit: the two branch opcodes must differ");
      end
   endgenerate

   cj_form_e          form;
   logic [COND_W-1:0] cond;
   logic [XLEN-1:0]   opnd_b;
   cj_cmp_t           cmp;
   logic              taken_c;
   logic              bad_c;
   logic [XLEN-1:0]   next_ip_c;

   cj_decode #(
      .XLEN       (XLEN),
      .OPC_W      (OPC_W),
      .COND_W     (COND_W),
      .IMM_W      (IMM_W),
      .OPC_REG    (OPC_REG),
      .OPC_IMM    (OPC_IMM),
      .IMM_SIGNED (IMM_SIGNED)
   ) u_decode (
      .clk     (clk),
      .rst_n   (rst_n),
      .instr   (instr_i),
      .rs2_val (rs2_val_i),
      .form    (form),
      .cond    (cond),
      .opnd_b  (opnd_b)
   );

   cj_compare #(
      .XLEN       (XLEN),
      .SHARED_SUB (SHARED_SUB)
   ) u_compare (
      .clk   (clk),
      .rst_n (rst_n),
      .a     (rs1_val_i),
      .b     (opnd_b),
      .cmp   (cmp)
   );

   cj_select #(
      .XLEN    (XLEN),
      .COND_W  (COND_W),
      .IP_STEP (IP_STEP)
   ) u_select (
      .clk     (clk),
      .rst_n   (rst_n),
      .form    (form),
      .cond    (cond),
      .cmp     (cmp),
      .ip      (ip_i),
      .target  (target_i),
      .taken   (taken_c),
      .bad     (bad_c),
      .next_ip (next_ip_c)
   );

   generate
      if (OUT_REG) begin : g_reg_out
         logic            taken_q;
         logic            bad_q;
         logic [XLEN-1:0] next_ip_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               taken_q   <= 1'b0;
               bad_q     <= 1'b0;
               next_ip_q <= '0;
            end else begin
               taken_q   <= taken_c;
               bad_q     <= bad_c;
               next_ip_q <= next_ip_c;
            end
         end

         assign taken_o    = taken_q;
         assign bad_cond_o = bad_q;
         assign next_ip_o  = next_ip_q;

         // R10: a non-branch opcode in the previous cycle gives an idle result
         p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && ($past(form) == CJ_FORM_NONE))
               |-> (!taken_o && !bad_cond_o));

         // R11: a not-taken result points at the following instruction
         p_seq_r11: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !taken_o)
               |-> (next_ip_o == ($past(ip_i) + XLEN'(IP_STEP))));

         // R9: an undefined condition flag always pairs with a sequential IP
         p_bad_seq_r9: assert property (@(posedge clk) disable iff (!rst_n)
            bad_cond_o |-> !taken_o);
      end else begin : g_comb_out
         assign taken_o    = taken_c;
         assign bad_cond_o = bad_c;
         assign next_ip_o  = next_ip_c;

         // R10: idle opcode never reports a jump or a bad condition
         p_idle_comb_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (form == CJ_FORM_NONE) |-> (!taken_o && !bad_cond_o));

         // R11: sequential address when not taken
         p_seq_comb_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !taken_o |-> (next_ip_o == (ip_i + XLEN'(IP_STEP))));
      end
   endgenerate

endmodule

// File: tb/tb_cj_branch_unit.sv
module tb_cj_branch_unit;

   localparam logic [7:0] OPR = 8'h40;
   localparam logic [7:0] OPI = 8'h41;

   logic        clk;
   logic        rst_n;
   logic [31:0] instr_i;
   logic [31:0] rs1_val_i;
   logic [31:0] rs2_val_i;
   logic [31:0] ip_i;
   logic [31:0] target_i;
   logic        taken_o;
   logic [31:0] next_ip_o;
   logic        bad_cond_o;

   int checks   = 0;
   int failures = 0;
   bit finished = 1'b0;

   cj_branch_unit dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .instr_i    (instr_i),
      .rs1_val_i  (rs1_val_i),
      .rs2_val_i  (rs2_val_i),
      .ip_i       (ip_i),
      .target_i   (target_i),
      .taken_o    (taken_o),
      .next_ip_o  (next_ip_o),
      .bad_cond_o (bad_cond_o)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   function automatic logic [31:0] mk(input logic [7:0] opc, input logic [3:0] cnd,
                                      input logic [15:0] lo);
      return {opc, cnd, 4'h2, lo};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive one instruction at a falling edge, let one rising edge register it
   task automatic issue(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] ip, input logic [31:0] tgt);
      @(negedge clk);
      instr_i   = ins;
      rs1_val_i = a;
      rs2_val_i = b;
      ip_i      = ip;
      target_i  = tgt;
      @(negedge clk);
   endtask

   task automatic expect_out(input string req, input logic tk, input logic bd,
                             input logic [31:0] nip);
      chk({req, " taken"}, {31'd0, taken_o}, {31'd0, tk});
      chk({req, " bad"}, {31'd0, bad_cond_o}, {31'd0, bd});
      chk({req, " next_ip"}, next_ip_o, nip);
   endtask

   task automatic t_reset_r1();
      chk("R1 taken", {31'd0, taken_o}, 32'd0);
      chk("R1 bad", {31'd0, bad_cond_o}, 32'd0);
      chk("R1 next_ip", next_ip_o, 32'd0);
   endtask

   task automatic t_always_r3();
      issue(mk(OPR, 4'd0, 16'h0000), 32'd5, 32'd9, 32'd100, 32'h2000);
      expect_out("R3 reg", 1'b1, 1'b0, 32'h2000);
      issue(mk(OPI, 4'd0, 16'h7777), 32'd5, 32'd9, 32'd200, 32'h3000);
      expect_out("R3 imm", 1'b1, 1'b0, 32'h3000);
   endtask

   task automatic t_eq_ne_r4();
      issue(mk(OPR, 4'd1, 16'h0), 32'h1234, 32'h1234, 32'd10, 32'h40);
      expect_out("R4 eq hit", 1'b1, 1'b0, 32'h40);
      issue(mk(OPR, 4'd1, 16'h0), 32'h1234, 32'h1235, 32'd10, 32'h40);
      expect_out("R4 eq miss", 1'b0, 1'b0, 32'd11);
      issue(mk(OPR, 4'd2, 16'h0), 32'h1234, 32'h1235, 32'd10, 32'h40);
      expect_out("R4 ne hit", 1'b1, 1'b0, 32'h40);
      issue(mk(OPR, 4'd2, 16'h0), 32'h1234, 32'h1234, 32'd10, 32'h40);
      expect_out("R4 ne miss", 1'b0, 1'b0, 32'd11);
   endtask

   task automatic t_unsigned_r5();
      issue(mk(OPR, 4'd3, 16'h0), 32'hFFFF_FFFF, 32'd1, 32'd20, 32'h80);
      expect_out("R5 ugt big", 1'b1, 1'b0, 32'h80);
      issue(mk(OPR, 4'd3, 16'h0), 32'd7, 32'd7, 32'd20, 32'h80);
      expect_out("R5 ugt equal", 1'b0, 1'b0, 32'd21);
      issue(mk(OPR, 4'd4, 16'h0), 32'd7, 32'd7, 32'd20, 32'h80);
      expect_out("R5 uge equal", 1'b1, 1'b0, 32'h80);
      issue(mk(OPR, 4'd4, 16'h0), 32'd1, 32'hFFFF_FFFF, 32'd20, 32'h80);
      expect_out("R5 uge small", 1'b0, 1'b0, 32'd21);
   endtask

   task automatic t_signed_r6();
      issue(mk(OPR, 4'd5, 16'h0), 32'd1, 32'hFFFF_FFFF, 32'd30, 32'h90);
      expect_out("R6 sgt pos>neg", 1'b1, 1'b0, 32'h90);
      issue(mk(OPR, 4'd5, 16'h0), 32'hFFFF_FFFF, 32'd1, 32'd30, 32'h90);
      expect_out("R6 sgt neg>pos", 1'b0, 1'b0, 32'd31);
      issue(mk(OPR, 4'd6, 16'h0), 32'h8000_0000, 32'h8000_0000, 32'd30, 32'h90);
      expect_out("R6 sge equal min", 1'b1, 1'b0, 32'h90);
      issue(mk(OPR, 4'd6, 16'h0), 32'h8000_0000, 32'h7FFF_FFFF, 32'd30, 32'h90);
      expect_out("R6 sge min vs max", 1'b0, 1'b0, 32'd31);
   endtask

   task automatic t_reg_form_r7();
      issue(mk(OPR, 4'd1, 16'hABCD), 32'd3, 32'd3, 32'd40, 32'hA0);
      expect_out("R7 low bits ignored", 1'b1, 1'b0, 32'hA0);
      issue(mk(OPR, 4'd1, 16'h0003), 32'd3, 32'd4, 32'd40, 32'hA0);
      expect_out("R7 uses rs2 not imm", 1'b0, 1'b0, 32'd41);
   endtask

   task automatic t_imm_form_r8();
      issue(mk(OPI, 4'd1, 16'hFFFF), 32'hFFFF_FFFF, 32'd0, 32'd50, 32'hB0);
      expect_out("R8 sext all ones", 1'b1, 1'b0, 32'hB0);
      issue(mk(OPI, 4'd3, 16'h8000), 32'h0000_8000, 32'd0, 32'd50, 32'hB0);
      expect_out("R8 unsigned vs sext", 1'b0, 1'b0, 32'd51);
      issue(mk(OPI, 4'd5, 16'h8000), 32'h0000_8000, 32'd0, 32'd50, 32'hB0);
      expect_out("R8 signed vs sext", 1'b1, 1'b0, 32'hB0);
      issue(mk(OPI, 4'd1, 16'h0005), 32'd5, 32'h99, 32'd50, 32'hB0);
      expect_out("R8 rs2 ignored", 1'b1, 1'b0, 32'hB0);
   endtask

   task automatic t_bad_cond_r9();
      issue(mk(OPR, 4'd7, 16'h0), 32'd1, 32'd1, 32'd60, 32'hC0);
      expect_out("R9 cond7", 1'b0, 1'b1, 32'd61);
      issue(mk(OPR, 4'd15, 16'h0), 32'd1, 32'd1, 32'd60, 32'hC0);
      expect_out("R9 cond15", 1'b0, 1'b1, 32'd61);
      issue(mk(OPI, 4'd9, 16'h0001), 32'd1, 32'd1, 32'd60, 32'hC0);
      expect_out("R9 imm cond9", 1'b0, 1'b1, 32'd61);
   endtask

   task automatic t_idle_r10();
      issue(mk(8'h00, 4'd0, 16'h0), 32'd1, 32'd1, 32'd70, 32'hD0);
      expect_out("R10 opcode 00", 1'b0, 1'b0, 32'd71);
      issue(mk(8'h42, 4'd8, 16'h0), 32'd1, 32'd1, 32'd70, 32'hD0);
      expect_out("R10 opcode 42", 1'b0, 1'b0, 32'd71);
   endtask

   task automatic t_wrap_r11();
      issue(mk(OPR, 4'd2, 16'h0), 32'd4, 32'd4, 32'hFFFF_FFFF, 32'hE0);
      expect_out("R11 wrap", 1'b0, 1'b0, 32'd0);
   endtask

   task automatic t_latency_r2();
      issue(mk(OPR, 4'd0, 16'h0), 32'd0, 32'd0, 32'd80, 32'hF00);
      @(negedge clk);
      instr_i = mk(8'h00, 4'd0, 16'h0);
      ip_i    = 32'd90;
      #2;
      chk("R2 old taken held", {31'd0, taken_o}, 32'd1);
      chk("R2 old next held", next_ip_o, 32'hF00);
      @(negedge clk);
      expect_out("R2 new after edge", 1'b0, 1'b0, 32'd91);
   endtask

   initial begin
      rst_n     = 1'b0;
      instr_i   = '0;
      rs1_val_i = '0;
      rs2_val_i = '0;
      ip_i      = '0;
      target_i  = '0;
      repeat (3) @(negedge clk);
      t_reset_r1();
      rst_n = 1'b1;
      t_always_r3();
      t_eq_ne_r4();
      t_unsigned_r5();
      t_signed_r6();
      t_reg_form_r7();
      t_imm_form_r8();
      t_bad_cond_r9();
      t_idle_r10();
      t_wrap_r11();
      t_latency_r2();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule